// File: doc/BRIEF.md
# Rotational-Interleaving Slice Selector

This block chooses the last-level cache slice that serves a request in a tiled multicore whose slices are connected as a folded two-dimensional torus. Each request carries the coordinates of the tile that issued it, a physical address, an access class and, for private pages, the tile that owns the page. The block returns the tile ID of the destination slice one cycle later, behind a valid/ready handshake.

Private data goes to the owner slice recorded with the page. Shared data is interleaved over every slice by block address, so each shared block has one fixed home. Instruction fetches are spread over a small cluster of neighbouring slices. Every tile carries a rotational ID, and the cluster slice whose rotational ID matches a few address bits holds the block. As a result, clusters that overlap agree on where each instruction block lives, and a single probe finds it. The cluster size is a parameter with a 4-slice and an 8-slice variant.

Tile IDs are numbered row-major: tile = y * MESH_X + x.

Top module: `ri_slice_select`

## Requirements
- R1: After reset, out_valid is low, and in_ready is high while out_valid is low.
- R2: A request of class 0 (private) produces out_tile equal to its owner_tile input.
- R3: A request of class 1 (shared) produces out_tile = (req_addr >> 6) mod (MESH_X*MESH_Y). Bits [5:0] of the address are the block offset and never affect the result.
- R4: Class 3 is reserved and is mapped exactly like class 1 (shared). Class 2 is instruction.
- R5: The rotational ID of tile (x, y) is (x + y*log2(K)) mod K, where K is the cluster size.
- R6: For class 2, the target rotational ID is req_addr[6 +: log2(K)]. When it equals the requester's rotational ID, the local tile is returned.
- R7: With K=4, the slice chosen for class 2 is the one among local, east (x+1), west (x-1) and south (y+1) whose rotational ID equals the target. Coordinates wrap around the torus edges.
- R8: With K=8, the cluster is the set of offsets (dx,dy) in {(0,0),(1,0),(2,0),(0,1),(1,1),(0,-1),(-2,0),(-1,0)}. The block chooses the member whose rotational ID equals the target, with coordinates wrapping.
- R9: A request accepted on a clock edge (in_valid and in_ready both high) gives out_valid high after that edge, with its result on out_tile.
- R10: While out_valid is high and out_ready is low, in_ready is low and out_tile and out_valid hold.
- R11: For any instruction address, the rotational ID of the chosen tile equals the target rotational ID, whichever tile makes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| req_x | input | $clog2(MESH_X) | Requesting tile column |
| req_y | input | $clog2(MESH_Y) | Requesting tile row |
| req_addr | input | ADDR_W | Physical address |
| req_class | input | 2 | 0 private, 1 shared, 2 instruction, 3 reserved |
| owner_tile | input | $clog2(MESH_X*MESH_Y) | Owner slice of a private page |
| out_valid | output | 1 | Destination present |
| out_ready | input | 1 | Destination accepted by the consumer |
| out_tile | output | $clog2(MESH_X*MESH_Y) | Destination tile ID |

## Verification
The bench builds two copies of the block. The first uses the default 4x4 torus with K=4, which lets it sweep every tile against every target ID and reach the wraparound cases on all four edges. The second uses an 8x8 torus with K=8, which is the smallest square mesh on which the 8-slice cluster wraps consistently, so the larger offset set and its wraparound at two-column distance are exercised too. The expected slice is found by searching the cluster members for a matching rotational ID, not by computing the offset.

// File: rtl/ri_slice_pkg.sv
package ri_slice_pkg;
   typedef enum logic [1:0] {
      ACC_PRIVATE = 2'd0,
      ACC_SHARED  = 2'd1,
      ACC_INSTR   = 2'd2,
      ACC_RSVD    = 2'd3
   } acc_class_e;

   localparam int BLK_OFF_BITS = 6;
endpackage

// File: rtl/ri_rot_id.sv
module ri_rot_id #(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   parameter int K      = 4,
   localparam int XW    = $clog2(MESH_X),
   localparam int YW    = $clog2(MESH_Y),
   localparam int LOGK  = $clog2(K)
) (
   input  logic [XW-1:0]   x,
   input  logic [YW-1:0]   y,
   output logic [LOGK-1:0] rid
);
   // Truncation to LOGK bits is the modulo K, since K is a power of two.
   always_comb begin
      rid = LOGK'(int'(x) + int'(y) * LOGK);
   end
endmodule

// File: rtl/ri_cluster_pick.sv
module ri_cluster_pick #(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   parameter int K      = 4,
   localparam int XW    = $clog2(MESH_X),
   localparam int YW    = $clog2(MESH_Y),
   localparam int TW    = $clog2(MESH_X * MESH_Y),
   localparam int LOGK  = $clog2(K)
) (
   input  logic [XW-1:0]   x,
   input  logic [YW-1:0]   y,
   input  logic [LOGK-1:0] local_rid,
   input  logic [LOGK-1:0] target_rid,
   output logic [TW-1:0]   tile
);
   logic [LOGK-1:0] delta;
   int              dx;
   int              dy;
   int              nx;
   int              ny;

   assign delta = target_rid - local_rid;

   generate
      if (K == 4) begin : g_k4
         always_comb begin
            dx = 0;
            dy = 0;
            unique case (delta)
               2'd0: begin dx = 0;  dy = 0; end
               2'd1: begin dx = 1;  dy = 0; end
               2'd2: begin dx = 0;  dy = 1; end
               default: begin dx = -1; dy = 0; end
            endcase
         end
      end else begin : g_k8
         always_comb begin
            dx = 0;
            dy = 0;
            unique case (delta)
               3'd0: begin dx = 0;  dy = 0;  end
               3'd1: begin dx = 1;  dy = 0;  end
               3'd2: begin dx = 2;  dy = 0;  end
               3'd3: begin dx = 0;  dy = 1;  end
               3'd4: begin dx = 1;  dy = 1;  end
               3'd5: begin dx = 0;  dy = -1; end
               3'd6: begin dx = -2; dy = 0;  end
               default: begin dx = -1; dy = 0; end
            endcase
         end
      end
   endgenerate

   always_comb begin
      nx   = (int'(x) + dx + MESH_X) % MESH_X;
      ny   = (int'(y) + dy + MESH_Y) % MESH_Y;
      tile = TW'(ny * MESH_X + nx);
   end
endmodule

// File: rtl/ri_shared_map.sv
module ri_shared_map #(
   parameter int NUM_TILES = 16,
   parameter int ADDR_W    = 40,
   parameter int OFF       = 6,
   localparam int TW       = $clog2(NUM_TILES),
   localparam int BW       = ADDR_W - OFF
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TW-1:0]     tile
);
   logic [BW-1:0] blk;
   assign blk = addr[ADDR_W-1:OFF];

   generate
      if ((1 << TW) == NUM_TILES) begin : g_pow2
         assign tile = blk[TW-1:0];
      end else begin : g_mod
         logic [BW-1:0] rem;
         assign rem  = blk % BW'(NUM_TILES);
         assign tile = rem[TW-1:0];
      end
   endgenerate
endmodule

// File: rtl/ri_slice_select.sv
module ri_slice_select #(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   parameter int K      = 4,
   parameter int ADDR_W = 40,
   localparam int NUM_TILES = MESH_X * MESH_Y,
   localparam int XW    = $clog2(MESH_X),
   localparam int YW    = $clog2(MESH_Y),
   localparam int TW    = $clog2(NUM_TILES),
   localparam int LOGK  = $clog2(K),
   localparam int OFF   = ri_slice_pkg::BLK_OFF_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [XW-1:0]     req_x,
   input  logic [YW-1:0]     req_y,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_class,
   input  logic [TW-1:0]     owner_tile,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [TW-1:0]     out_tile
);
   import ri_slice_pkg::*;

   if (!(K == 4 || K == 8)) begin : g_bad_k
      $error("cluster size must be 4 or 8");
   end
   if (MESH_X < K / 2 + 1 || MESH_Y < 3) begin : g_bad_mesh
      $error("mesh too small for the cluster");
   end
   if ((MESH_X % K) != 0 || ((MESH_Y * LOGK) % K) != 0) begin : g_bad_wrap
      $error("rotational IDs would not wrap consistently on this torus");
   end
   if (ADDR_W < OFF + TW + LOGK) begin : g_bad_addr
      $error("address too narrow");
   end

   logic [LOGK-1:0] local_rid;
   logic [LOGK-1:0] target_rid;
   logic [TW-1:0]   instr_tile;
   logic [TW-1:0]   shared_tile;
   logic [TW-1:0]   next_tile;
   logic            take;

   assign target_rid = req_addr[OFF +: LOGK];

   ri_rot_id #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .K(K)) u_rid (
      .x   (req_x),
      .y   (req_y),
      .rid (local_rid)
   );

   ri_cluster_pick #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .K(K)) u_pick (
      .x          (req_x),
      .y          (req_y),
      .local_rid  (local_rid),
      .target_rid (target_rid),
      .tile       (instr_tile)
   );

   ri_shared_map #(.NUM_TILES(NUM_TILES), .ADDR_W(ADDR_W), .OFF(OFF)) u_shr (
      .addr (req_addr),
      .tile (shared_tile)
   );

   always_comb begin
      unique case (acc_class_e'(req_class))
         ACC_PRIVATE: next_tile = owner_tile;
         ACC_INSTR:   next_tile = instr_tile;
         default:     next_tile = shared_tile;
      endcase
   end

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tile  <= '0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_tile  <= next_tile;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ri_slice_select_chk.sv
module ri_slice_select_chk #(
   parameter int TW        = 4,
   parameter int NUM_TILES = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic [1:0]    req_class,
   input logic [TW-1:0] owner_tile,
   input logic          out_valid,
   input logic          out_ready,
   input logic [TW-1:0] out_tile
);
   // R9
   accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_tile));

   // R10
   drop_only_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));

   // R2
   private_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && req_class == 2'd0 |=> out_tile == $past(owner_tile));

   // R3
   tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_tile) < NUM_TILES);
endmodule

bind ri_slice_select ri_slice_select_chk #(.TW(TW), .NUM_TILES(NUM_TILES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .req_class  (req_class),
   .owner_tile (owner_tile),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_tile   (out_tile)
);

// File: tb/ri_slice_select_test.sv
`timescale 1ns/1ps
module ri_slice_select_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;

   // K=4 instance on 4x4
   logic        a_iv = 1'b0, a_ir, a_ov, a_or = 1'b1;
   logic [1:0]  a_x = '0, a_y = '0, a_cls = '0;
   logic [39:0] a_addr = '0;
   logic [3:0]  a_own = '0, a_tile;

   ri_slice_select uut (
      .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
      .req_x(a_x), .req_y(a_y), .req_addr(a_addr), .req_class(a_cls),
      .owner_tile(a_own), .out_valid(a_ov), .out_ready(a_or), .out_tile(a_tile)
   );

   // K=8 instance on 8x8
   logic        b_iv = 1'b0, b_ir, b_ov, b_or = 1'b1;
   logic [2:0]  b_x = '0, b_y = '0;
   logic [1:0]  b_cls = '0;
   logic [39:0] b_addr = '0;
   logic [5:0]  b_own = '0, b_tile;

   ri_slice_select #(.MESH_X(8), .MESH_Y(8), .K(8), .ADDR_W(40)) uut_k8 (
      .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir),
      .req_x(b_x), .req_y(b_y), .req_addr(b_addr), .req_class(b_cls),
      .owner_tile(b_own), .out_valid(b_ov), .out_ready(b_or), .out_tile(b_tile)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rid_of(int x, int y, int k);
      int lk = (k == 4) ? 2 : 3;
      return (x + y * lk) % k;
   endfunction

   // Search the cluster for the member whose rotational ID matches.
   function automatic int pick(int x, int y, int tgt, int k, int m);
      int ox4[4] = '{0, 1, -1, 0};
      int oy4[4] = '{0, 0, 0, 1};
      int ox8[8] = '{0, 1, 2, 0, 1, 0, -2, -1};
      int oy8[8] = '{0, 0, 0, 1, 1, -1, 0, 0};
      for (int i = 0; i < k; i++) begin
         int nx = (x + ((k == 4) ? ox4[i] : ox8[i]) + m) % m;
         int ny = (y + ((k == 4) ? oy4[i] : oy8[i]) + m) % m;
         if (rid_of(nx, ny, k) == tgt) return ny * m + nx;
      end
      return -1;
   endfunction

   task automatic send_a(int x, int y, logic [39:0] addr, int cls, int own);
      @(negedge clk);
      a_x = 2'(x); a_y = 2'(y); a_addr = addr; a_cls = 2'(cls); a_own = 4'(own);
      a_iv = 1'b1; a_or = 1'b1;
      @(posedge clk);
      @(negedge clk);
      a_iv = 1'b0;
   endtask

   task automatic send_b(int x, int y, logic [39:0] addr);
      @(negedge clk);
      b_x = 3'(x); b_y = 3'(y); b_addr = addr; b_cls = 2'd2; b_iv = 1'b1;
      @(posedge clk);
      @(negedge clk);
      b_iv = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 out_valid after reset", a_ov, 0);
      chk("R1 in_ready after reset", a_ir, 1);
      chk("R1 k8 out_valid after reset", b_ov, 0);
   endtask

   task automatic t_private;
      send_a(1, 2, 40'h12345_6789C, 0, 13);
      chk("R2 private owner", a_tile, 13);
      chk("R9 valid after accept", a_ov, 1);
      send_a(3, 3, 40'h0, 0, 0);
      chk("R2 private owner zero", a_tile, 0);
   endtask

   task automatic t_shared;
      logic [39:0] ad [4] = '{40'h0, 40'h3FF, 40'hA_BCDE_F07F, 40'hFF_FFFF_FFC0};
      foreach (ad[i]) begin
         send_a(2, 1, ad[i], 1, 9);
         chk("R3 shared interleave", a_tile, int'((ad[i] >> 6) % 16));
      end
      // offset bits do not move the block
      send_a(0, 0, 40'h1C0 | 40'h3F, 1, 0);
      chk("R3 offset ignored", a_tile, 7);
      send_a(0, 0, 40'hA_BCDE_F07F, 3, 5);
      chk("R4 reserved class as shared", a_tile, int'((40'hA_BCDE_F07F >> 6) % 16));
   endtask

   task automatic t_instr4;
      for (int y = 0; y < 4; y++)
         for (int x = 0; x < 4; x++)
            for (int t = 0; t < 4; t++) begin
               logic [39:0] ad = (40'h5A5A_0 << 8) | (40'(t) << 6) | 40'h2B;
               send_a(x, y, ad, 2, 11);
               chk("R7 k4 cluster pick", a_tile, pick(x, y, t, 4, 4));
               chk("R11 k4 chosen rid", rid_of(a_tile % 4, a_tile / 4, 4), t);
               if (t == rid_of(x, y, 4))
                  chk("R6 local when rid matches", a_tile, y * 4 + x);
            end
   endtask

   task automatic t_wrap4;
      // R5 tile (3,3) has rid (3+6)%4=1; target 2 -> east wraps to (0,3)=12
      send_a(3, 3, 40'h2 << 6, 2, 0);
      chk("R7 east wrap", a_tile, 12);
      // tile (0,3) rid 2; target 1 -> west wraps to (3,3)=15
      send_a(0, 3, 40'h1 << 6, 2, 0);
      chk("R7 west wrap", a_tile, 15);
      // tile (2,3) rid 0; target 2 -> south wraps to (2,0)=2
      send_a(2, 3, 40'h2 << 6, 2, 0);
      chk("R7 south wrap", a_tile, 2);
      // R5 tile (1,2): rid (1+4)%4=1; target 1 -> local 9
      send_a(1, 2, 40'h1 << 6, 2, 0);
      chk("R5 rotational id local", a_tile, 9);
   endtask

   task automatic t_instr8;
      for (int y = 0; y < 8; y++)
         for (int x = 0; x < 8; x++)
            for (int t = 0; t < 8; t++) begin
               send_b(x, y, (40'h77 << 12) | (40'(t) << 6) | 40'h11);
               chk("R8 k8 cluster pick", b_tile, pick(x, y, t, 8, 8));
               chk("R11 k8 chosen rid", rid_of(b_tile % 8, b_tile / 8, 8), t);
            end
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      a_x = 2'd1; a_y = 2'd0; a_addr = 40'h0; a_cls = 2'd0; a_own = 4'd6;
      a_iv = 1'b1; a_or = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 valid after accept", a_ov, 1);
      chk("R10 in_ready low while stalled", a_ir, 0);
      a_own = 4'd10;
      @(posedge clk);
      @(negedge clk);
      chk("R10 tile held", a_tile, 6);
      chk("R10 valid held", a_ov, 1);
      a_or = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10 next taken on release", a_tile, 10);
      a_iv = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 valid drops when idle", a_ov, 0);
      chk("R1 in_ready when empty", a_ir, 1);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_private();
      t_shared();
      t_instr4();
      t_wrap4();
      t_instr8();
      t_backpressure();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule